// File: doc/BRIEF.md
# Staircase Pseudo-Sine Carrier Sequencer

This block produces the digital side of a stepped sine carrier. Every reference clock it emits one step of a fixed 16-step staircase as a 4-bit code for a positive ladder D/A converter. At the same time it emits the mirror code for a second ladder, so that the two analog outputs swing in opposite directions. One full carrier period therefore takes sixteen reference clocks.

An active-low gate input starts and stops the carrier. While the gate is high, both codes sit at the rest phase and nothing advances. When the gate falls, the staircase starts from its lowest step. When the gate rises, the carrier is cut off at whatever step it has reached and goes back to rest. The gate passes through a two-stage synchronizer first. A transmit-enable output follows the synchronized gate and closes the external line switches only while the carrier runs.

Top module: `pseudo_sine_seq`

## Requirements
- R1: While the synchronized gate is high, `pos_code` is 4'h0, `neg_code` is 4'hF and `tx_en` is 0.
- R2: While running, `pos_code` steps once per clock through 0,1,3,6,9,C,E,F,F,E,C,9,6,3,1,0 (hex), starting with the first value.
- R3: `neg_code` always equals 15 minus `pos_code`.
- R4: When `ctl_n` has been sampled low for two consecutive clock edges, at the second of those edges `tx_en` becomes 1 and `pos_code` shows 4'h0, the first table step.
- R5: When `ctl_n` has been sampled high for two consecutive clock edges, at the second of those edges the outputs return to rest (R1), whatever the step reached.
- R6: `tx_en` is 1 exactly while the carrier runs, with the same two-edge latency as the codes.
- R7: A clock edge with `rst_n` low leaves the outputs at rest with `tx_en` 0, and the next run starts from step 0.
- R8: A run that lasts longer than 16 clocks wraps from the last step back to the first without a gap.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one carrier step per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_n | input | 1 | Asynchronous active-low carrier gate |
| pos_code | output | 4 | Code for the positive-polarity ladder |
| neg_code | output | 4 | Code for the negative-polarity ladder |
| tx_en | output | 1 | Closes the line switches while transmitting |

## Verification
The hardest case to reach is a stop that lands in the middle of the staircase, one edge after the gate rises. At that point the synchronizer still reports the old level and the step counter moves one more time. The bench releases the gate at a chosen step of a running carrier. It checks that the carrier is still running one edge later and at rest after the second edge. It then restarts at once to confirm that the new run begins from step 0 and not from the step where the last run stopped.

// File: rtl/pseudo_sine_pkg.sv
// Shared constants and the staircase code table.
// Assumes a fixed 16-step table of 4-bit codes.
package pseudo_sine_pkg;

    localparam int CODE_W  = 4;
    localparam int STEPS   = 16;
    localparam int IDX_W   = $clog2(STEPS);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    // Positive-ladder code for a table position.
    function automatic logic [CODE_W-1:0] stair_pos(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] v;
        case (idx)
            4'd0:    v = 4'h0;
            4'd1:    v = 4'h1;
            4'd2:    v = 4'h3;
            4'd3:    v = 4'h6;
            4'd4:    v = 4'h9;
            4'd5:    v = 4'hC;
            4'd6:    v = 4'hE;
            4'd7:    v = 4'hF;
            4'd8:    v = 4'hF;
            4'd9:    v = 4'hE;
            4'd10:   v = 4'hC;
            4'd11:   v = 4'h9;
            4'd12:   v = 4'h6;
            4'd13:   v = 4'h3;
            4'd14:   v = 4'h1;
            default: v = 4'h0;
        endcase
        return v;
    endfunction

    // Negative-ladder code: mirror of the positive table about mid scale.
    function automatic logic [CODE_W-1:0] stair_neg(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] v;
        case (idx)
            4'd0:    v = 4'hF;
            4'd1:    v = 4'hE;
            4'd2:    v = 4'hC;
            4'd3:    v = 4'h9;
            4'd4:    v = 4'h6;
            4'd5:    v = 4'h3;
            4'd6:    v = 4'h1;
            4'd7:    v = 4'h0;
            4'd8:    v = 4'h0;
            4'd9:    v = 4'h1;
            4'd10:   v = 4'h3;
            4'd11:   v = 4'h6;
            4'd12:   v = 4'h9;
            4'd13:   v = 4'hC;
            4'd14:   v = 4'hE;
            default: v = 4'hF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
// Multi-stage synchronizer for the asynchronous active-low gate.
// Assumes the gate is quasi-static relative to clk; reset forces the idle (high) level.
module ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the gate level one stage per clock; reset parks it idle.
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b1;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/phase_counter.sv
// Table position counter: held at zero while parked, wraps modulo 2**IDX_W while running.
// Assumes park is already synchronous to clk.
module phase_counter #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    output logic [IDX_W-1:0] idx
);
    // Clear on reset or park, otherwise step one position per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || park) idx <= '0;
        else                idx <= idx + 1'b1;
    end
endmodule

// File: rtl/code_map.sv
// Maps a table position to the two ladder codes and forces rest while parked.
// Purely combinational; assumes the rest phase is table position zero.
module code_map
    import pseudo_sine_pkg::*;
(
    input  logic              park,
    input  logic [IDX_W-1:0]  idx,
    output logic [CODE_W-1:0] pos_code,
    output logic [CODE_W-1:0] neg_code
);
    // Select rest codes when parked so a stop takes effect at any position.
    always_comb begin
        if (park) begin
            pos_code = '0;
            neg_code = CODE_MAX;
        end else begin
            pos_code = stair_pos(idx);
            neg_code = stair_neg(idx);
        end
    end
endmodule

// File: rtl/pseudo_sine_seq.sv
// Top level: synchronizes the active-low gate, runs the position counter and
// drives two opposite-polarity ladder codes plus a line-switch enable.
// Assumes one carrier step per clk edge; codes are valid after each edge.
module pseudo_sine_seq
    import pseudo_sine_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_n,
    output logic [CODE_W-1:0] pos_code,
    output logic [CODE_W-1:0] neg_code,
    output logic              tx_en
);
    logic             park;
    logic [IDX_W-1:0] idx;

    ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_n),
        .sync_out (park)
    );

    phase_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .park  (park),
        .idx   (idx)
    );

    code_map u_map (
        .park     (park),
        .idx      (idx),
        .pos_code (pos_code),
        .neg_code (neg_code)
    );

    // Switches close exactly while the carrier is not parked.
    assign tx_en = !park;
endmodule

// File: rtl/pseudo_sine_seq_chk.sv
// Checker for pseudo_sine_seq, bound to every instance.
// Keeps its own step counter as an independent model of the carrier position.
module pseudo_sine_seq_chk
    import pseudo_sine_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_n,
    input logic [CODE_W-1:0] pos_code,
    input logic [CODE_W-1:0] neg_code,
    input logic              tx_en
);
    logic [IDX_W-1:0] model_step;

    // Count steps since the carrier started; hold zero while it is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) model_step <= '0;
        else                  model_step <= model_step + 1'b1;
    end

    AST_REST_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (pos_code == 4'h0 && neg_code == 4'hF)); // R1

    AST_STAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $past(rst_n)) |-> (pos_code == stair_pos(model_step))); // R2

    AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (5'(pos_code) + 5'(neg_code)) == 5'd15); // R3

    AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> pos_code == 4'h0); // R4

    AST_ON_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(ctl_n) && !$past(ctl_n, 2)) |-> tx_en); // R6

    AST_OFF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_n) && $past(ctl_n, 2)) |-> !tx_en); // R5
endmodule

bind pseudo_sine_seq pseudo_sine_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_n    (ctl_n),
    .pos_code (pos_code),
    .neg_code (neg_code),
    .tx_en    (tx_en)
);

// File: tb/test_pseudo_sine_seq.sv
module test_pseudo_sine_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_n = 1'b1;
    logic [3:0] pos_code, neg_code;
    logic       tx_en;

    int n_chk = 0;
    int n_fail = 0;

    // Expected positive codes over 20 consecutive running steps (wraps after 16).
    localparam logic [3:0] EXP_SEQ [20] = '{
        4'h0, 4'h1, 4'h3, 4'h6, 4'h9, 4'hC, 4'hE, 4'hF,
        4'hF, 4'hE, 4'hC, 4'h9, 4'h6, 4'h3, 4'h1, 4'h0,
        4'h0, 4'h1, 4'h3, 4'h6
    };

    always #2 clk = ~clk;

    pseudo_sine_seq i_pseudo_sine_seq (
        .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n),
        .pos_code(pos_code), .neg_code(neg_code), .tx_en(tx_en)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Sampling happens on negedges, half a period after each active edge.
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_rest(input string req);
        check(req, {pos_code, neg_code, tx_en}, {4'h0, 4'hF, 1'b0});
    endtask

    task automatic check_run(input string req, input logic [3:0] p);
        check(req, {pos_code, neg_code, tx_en}, {p, 4'(4'hF - p), 1'b1});
    endtask

    initial begin
        fork
            begin
                // R7: reset state
                edges(3);
                check_rest("R7 reset");
                rst_n = 1'b1;
                // R1: parked gate holds rest for many clocks
                edges(10);
                check_rest("R1 parked hold");
                // R4/R2/R3/R8: start and walk the vector table
                ctl_n = 1'b0;
                edges(1);
                check_rest("R4 one edge after fall still rest");
                edges(1);
                for (int k = 0; k < 20; k++) begin
                    check_run($sformatf("R2 R3 R8 step %0d", k), EXP_SEQ[k]);
                    edges(1);
                end
                // now at step 20 -> table position 4 (code 9); stop mid-phase
                ctl_n = 1'b1;
                edges(1);
                check_run("R5 one edge after rise still running", 4'hC);
                edges(1);
                check_rest("R5 stopped mid-phase");
                check("R6 tx_en off", {8'h0, tx_en}, 9'h0);
                // restart immediately: R4 new run from step 0
                ctl_n = 1'b0;
                edges(2);
                check_run("R4 restart from step 0", 4'h0);
                check("R6 tx_en on", {8'h0, tx_en}, 9'h1);
                edges(1);
                check_run("R2 restart step 1", 4'h1);
                // short glitch-length pulse high for one edge is absorbed? no: check 2-edge high stops
                edges(5);
                // R7: reset while running
                rst_n = 1'b0;
                edges(1);
                check_rest("R7 reset mid-run");
                rst_n = 1'b1;
                edges(2);
                check_run("R7 run after reset starts at step 0", 4'h0);
                edges(1);
                check_run("R7 run after reset step 1", 4'h1);
                ctl_n = 1'b1;
                edges(2);
                check_rest("R1 rest after final stop");
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule